// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one frame of data serially over three wires: a shift clock, a data input and a data output. It runs in one of two roles, chosen at run time. As master it makes the shift clock from the system clock with a programmable divider. As slave it follows a shift clock from outside, which it resynchronises into the system clock domain. One shift register serves both directions. It also handles both bit orders and both frame lengths (8 or 16 bits), so there is no second datapath.

Software uses a small register interface. It writes the mode and the transmit word, then sets the start bit. It waits for the done flag or the one-cycle interrupt, then reads the received word. The output bit changes on the falling edge of the shift clock. The input bit is sampled on the rising edge. The shift clock rests high between frames. There is one transfer buffer and no queue.

Top module: `sio_port`

## Requirements
- R1: Register map. Address 0 is the mode register: bit 0 selects master (1) or slave (0), bit 1 selects MSB-first (1) or LSB-first (0), bit 2 selects a 16-bit frame (1) or an 8-bit frame (0), and bits 7:4 hold the clock divider. Address 1 takes the transmit word on a write and returns the received word on a read. Address 2 starts a transfer when written with bit 0 set; when read, bit 0 is busy and bit 1 is done. After reset every readable field reads 0, sck_o and sout_o are high, and irq_o is low.
- R2: In master mode the shift clock stays at each level for exactly divider+1 system clock cycles. The first falling edge comes divider+1 cycles after the start. sck_oe_o is high, and sck_o is high whenever no transfer is in progress.
- R3: The first bit appears on sout_o as soon as the transfer starts. Each later bit is launched on a falling edge of the shift clock, and sout_o is stable at every other time during a master transfer. sin_i is sampled on each rising edge.
- R4: In MSB-first order the highest bit of the frame goes out first, and the first received bit lands in the highest position of the received word.
- R5: In LSB-first order bit 0 goes out first, and the first received bit lands in bit 0 of the received word.
- R6: A frame is 8 or 16 rising edges long. An 8-bit frame sends the low byte of the transmit word and returns its data in the low byte, with the upper byte reading 0.
- R7: In slave mode sck_oe_o is low and sck_o stays high. The external shift clock is passed through a two-flop synchroniser and its edges are detected in the system clock domain, so the port follows an external clock whose half period is several system cycles long.
- R8: Once the last bit of a frame is sampled, busy clears, the done flag sets and irq_o pulses high for exactly one cycle. A start write clears the done flag.
- R9: While busy, a start write is ignored and busy stays set. Writes to the mode and transmit registers are also ignored, so the frame in progress and the mode readback are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | One-cycle end-of-frame pulse |
| sck_i | input | 1 | External shift clock (slave mode) |
| sck_o | output | 1 | Shift clock driven in master mode |
| sck_oe_o | output | 1 | Shift clock output enable |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |

## Verification
The assertions rely on two things about the inputs. Software changes the mode only while the port is idle (the block itself enforces this). In slave mode the external clock spends enough system cycles at each level for the synchroniser to report every edge. The stimulus acts as the far end of the link. It changes sin_i only just after a falling edge, so the data is settled long before the next rising edge. In slave mode it drives the external clock with a half period of six system cycles, which is well beyond the three-cycle synchroniser latency. Register writes happen only between clock edges, and the mode changes made during a transfer exist only to check that they are ignored.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } sio_reg_e;

  localparam int MODE_MASTER_BIT = 0;
  localparam int MODE_MSB_BIT    = 1;
  localparam int MODE_WIDE_BIT   = 2;
  localparam int MODE_DIV_LSB    = 4;
  localparam int CTRL_START_BIT  = 0;
  localparam int STAT_BUSY_BIT   = 0;
  localparam int STAT_DONE_BIT   = 1;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == half_i);
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop; idle level is high
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sync_q[STAGES-1] && !sync_q[STAGES];
  assign fall_o = !sync_q[STAGES-1] && sync_q[STAGES];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              msb_first_i,
  input  logic              wide_i,
  input  logic              sample_i,
  input  logic              launch_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sin_q;
  logic [DATA_W-1:0] sh_final;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b,
                                                 input logic msb,
                                                 input logic wide);
    logic [DATA_W-1:0] r;
    r = v;
    if (msb) begin
      r = {v[DATA_W-2:0], b};
    end else if (wide) begin
      r = {b, v[DATA_W-1:1]};
    end else begin
      r[SHORT_W-2:0] = v[SHORT_W-1:1];
      r[SHORT_W-1]   = b;
    end
    return r;
  endfunction

  assign sout_o = msb_first_i ? (wide_i ? sh_q[DATA_W-1] : sh_q[SHORT_W-1]) : sh_q[0];
  assign last_o = sample_i && (cnt_q == (wide_i ? LAST_LONG : LAST_SHORT));

  // last bit goes straight from the pin into the word, skipping the sample latch
  assign sh_final  = shift_in(sh_q, sin_i, msb_first_i, wide_i);
  assign rx_word_o = wide_i ? sh_final : {{(DATA_W-SHORT_W){1'b0}}, sh_final[SHORT_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
      sin_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= load_data_i;
      cnt_q <= '0;
    end else if (sample_i) begin
      if (last_o) begin
        sh_q  <= sh_final;
        cnt_q <= '0;
      end else begin
        sin_q <= sin_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (launch_i && (cnt_q != '0)) begin
      sh_q <= shift_in(sh_q, sin_q, msb_first_i, wide_i);
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 4,
  parameter int REG_W   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  input  logic             sin_i,
  output logic             sout_o
);
  localparam int DIV_HI = MODE_DIV_LSB + DIV_W;

  logic              master_q, msb_q, wide_q, busy_q, done_q, irq_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_q, rx_q;

  logic mode_we, tx_we, start_req;
  logic m_sck, m_rise, m_fall, s_rise, s_fall;
  logic sample, launch, last_bit;
  logic [DATA_W-1:0] rx_word;
  logic unused_wr;

  assign unused_wr = ^{wr_data_i[REG_W-1:DIV_HI], wr_data_i[MODE_DIV_LSB-1:MODE_WIDE_BIT+1]};

  assign mode_we   = wr_en_i && (wr_addr_i == REG_MODE) && !busy_q;
  assign tx_we     = wr_en_i && (wr_addr_i == REG_DATA) && !busy_q;
  assign start_req = wr_en_i && (wr_addr_i == REG_CTRL) && wr_data_i[CTRL_START_BIT] && !busy_q;

  sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q && master_q),
    .half_i (div_q),
    .sck_o  (m_sck),
    .rise_o (m_rise),
    .fall_o (m_fall)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sck_i),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign sample = busy_q && (master_q ? m_rise : s_rise);
  assign launch = busy_q && (master_q ? m_fall : s_fall);

  sio_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_req),
    .load_data_i (tx_q),
    .msb_first_i (msb_q),
    .wide_i      (wide_q),
    .sample_i    (sample),
    .launch_i    (launch),
    .sin_i       (sin_i),
    .sout_o      (sout_o),
    .last_o      (last_bit),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      msb_q    <= 1'b0;
      wide_q   <= 1'b0;
      div_q    <= '0;
    end else if (mode_we) begin
      master_q <= wr_data_i[MODE_MASTER_BIT];
      msb_q    <= wr_data_i[MODE_MSB_BIT];
      wide_q   <= wr_data_i[MODE_WIDE_BIT];
      div_q    <= wr_data_i[DIV_HI-1:MODE_DIV_LSB];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tx_q <= '0;
    else if (tx_we) tx_q <= wr_data_i[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (start_req) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (last_bit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        irq_q  <= 1'b1;
        rx_q   <= rx_word;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_MODE: begin
        rd_data_o[MODE_MASTER_BIT]         = master_q;
        rd_data_o[MODE_MSB_BIT]            = msb_q;
        rd_data_o[MODE_WIDE_BIT]           = wide_q;
        rd_data_o[DIV_HI-1:MODE_DIV_LSB]   = div_q;
      end
      REG_DATA: rd_data_o = REG_W'(rx_q);
      REG_CTRL: begin
        rd_data_o[STAT_BUSY_BIT] = busy_q;
        rd_data_o[STAT_DONE_BIT] = done_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o    = irq_q;
  assign sck_o    = master_q ? m_sck : 1'b1;
  assign sck_oe_o = master_q;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             start_bit_i,
  input logic             busy_q,
  input logic             master_q,
  input logic [DIV_W-1:0] div_q,
  input logic             done_q,
  input logic             sck_o,
  input logic             sck_oe_o,
  input logic             sout_o,
  input logic             irq_o
);
  logic [DIV_W:0] lvl_cnt;
  logic           sck_d;
  logic           run, chg;

  assign run = busy_q && master_q;
  assign chg = (sck_o != sck_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b1;
      lvl_cnt <= '0;
    end else begin
      sck_d <= sck_o;
      if (!run)     lvl_cnt <= '0;
      else if (chg) lvl_cnt <= (DIV_W+1)'(1);
      else          lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  p_half_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && chg |-> lvl_cnt == ({1'b0, div_q} + 1'b1));

  p_half_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !chg |-> lvl_cnt <= {1'b0, div_q});

  p_sck_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sck_o);

  p_sout_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && $past(busy_q) && !$fell(sck_o) |-> $stable(sout_o));

  p_slave_pins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q |-> !sck_oe_o && sck_o);

  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_q && !busy_q);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && wr_en_i && wr_addr_i == 2'd2 && start_bit_i |=> busy_q || irq_o);

  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(master_q) && $stable(div_q));
endmodule

bind sio_port sio_port_chk #(.DIV_W(DIV_W)) u_sio_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .start_bit_i (wr_data_i[0]),
  .busy_q      (busy_q),
  .master_q    (master_q),
  .div_q       (div_q),
  .done_q      (done_q),
  .sck_o       (sck_o),
  .sck_oe_o    (sck_oe_o),
  .sout_o      (sout_o),
  .irq_o       (irq_o)
);

// File: tb/sio_port_test.sv
`timescale 1ns/1ps
module sio_port_test;
  localparam int HS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_o, sck_o, sck_oe_o, sout_o, sin_i, sck_i;

  logic slave_mode = 1'b0, s_sck = 1'b1, s_sin = 1'b0, m_sin = 1'b0;
  assign sck_i = s_sck;
  assign sin_i = slave_mode ? s_sin : m_sin;

  sio_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq_o), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .sin_i(sin_i), .sout_o(sout_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // far-end model shared by master transfers
  logic        peer_on = 1'b0, pmsb = 1'b0;
  int          flen = 8, pdiv = 0;
  logic [15:0] peer_word = '0, cap_m = '0;
  int          rises = 0, hp_bad = 0, last_tog = 0, irq_cnt = 0;
  logic        seen_start = 1'b0, prev_sck = 1'b1, low_sout = 1'b1;

  function automatic int bpos(int k);
    return pmsb ? flen - 1 - k : k;
  endfunction

  function automatic logic [15:0] fmask(logic [15:0] v, logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  function automatic logic [15:0] mode_word(logic m, logic msb, logic wide, logic [3:0] div);
    return {8'h00, div, 1'b0, wide, msb, m};
  endfunction

  always @(posedge clk) begin
    #1;
    if (irq_o) irq_cnt++;
    if (!peer_on) begin
      seen_start = 1'b0; rises = 0; hp_bad = 0; cap_m = '0;
    end else begin
      if (!seen_start && wr_en && wr_addr == 2'd2 && wr_data[0]) begin
        seen_start = 1'b1; last_tog = cyc;
      end
      if (rises == 0) m_sin = peer_word[bpos(0)];
      if (seen_start && sck_o != prev_sck) begin
        if (cyc - last_tog != pdiv + 1) hp_bad++;
        last_tog = cyc;
      end
      if (sck_o && !prev_sck) begin
        if (rises < flen) cap_m[bpos(rises)] = low_sout;
        rises++;
      end
      if (!sck_o && prev_sck && rises > 0 && rises < flen) m_sin = peer_word[bpos(rises)];
      if (!sck_o) low_sout = sout_o;
    end
    prev_sck = sck_o;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int t = 0; t < 5000; t++) begin
      rd(2'd2, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic master_xfer(logic msb, logic wide, logic [3:0] div,
                             logic [15:0] tx, logic [15:0] sw, logic inject);
    logic [15:0] v, mw;
    int base;
    mw = mode_word(1'b1, msb, wide, div);
    wr(2'd0, mw);
    wr(2'd1, tx);
    pmsb = msb; flen = wide ? 16 : 8; pdiv = int'(div); peer_word = sw;
    peer_on = 1'b1;
    base = irq_cnt;
    wr(2'd2, 16'h0001);
    rd(2'd2, v);
    chk("R8 start clears done, busy set", {30'd0, v[1:0]}, 32'd1);
    chk("R2 sck_oe in master", {31'd0, sck_oe_o}, 32'd1);
    if (inject) begin
      repeat (10) @(negedge clk);
      wr(2'd2, 16'h0001);
      rd(2'd2, v);
      chk("R9 busy held after second start", {31'd0, v[0]}, 32'd1);
      wr(2'd1, ~tx);
      wr(2'd0, 16'h0000);
    end
    wait_idle();
    peer_on = 1'b0;
    chk($sformatf("R3 %s sent bits", msb ? "R4" : "R5"), {16'd0, cap_m}, {16'd0, fmask(tx, wide)});
    rd(2'd1, v);
    chk($sformatf("R6 %s received word", msb ? "R4" : "R5"), {16'd0, v}, {16'd0, fmask(sw, wide)});
    chk("R6 rising edges per frame", rises, flen);
    chk("R2 half period", hp_bad, 0);
    chk("R8 one irq pulse", irq_cnt - base, 1);
    rd(2'd2, v);
    chk("R8 done set busy clear", {30'd0, v[1:0]}, 32'd2);
    chk("R2 sck idles high", {31'd0, sck_o}, 32'd1);
    if (inject) begin
      rd(2'd0, v);
      chk("R9 mode write ignored while busy", {16'd0, v}, {16'd0, mw});
    end
  endtask

  task automatic slave_xfer(logic msb, logic wide, logic [15:0] tx, logic [15:0] sw);
    logic [15:0] v, cap;
    int base;
    wr(2'd0, mode_word(1'b0, msb, wide, 4'd0));
    wr(2'd1, tx);
    pmsb = msb; flen = wide ? 16 : 8;
    slave_mode = 1'b1; s_sck = 1'b1; s_sin = sw[bpos(0)];
    cap = '0;
    repeat (4) @(negedge clk);
    base = irq_cnt;
    wr(2'd2, 16'h0001);
    rd(2'd2, v);
    chk("R8 slave start clears done", {30'd0, v[1:0]}, 32'd1);
    chk("R7 sck_oe low and sck_o high in slave", {30'd0, sck_oe_o, sck_o}, 32'd1);
    for (int k = 0; k < flen; k++) begin
      @(negedge clk);
      s_sck = 1'b0;
      if (k > 0) s_sin = sw[bpos(k)];
      repeat (HS) @(negedge clk);
      cap[bpos(k)] = sout_o;
      s_sck = 1'b1;
      repeat (HS) @(negedge clk);
    end
    rd(2'd2, v);
    chk("R7 slave done after last edge", {30'd0, v[1:0]}, 32'd2);
    chk($sformatf("R7 %s slave sent bits", msb ? "R4" : "R5"), {16'd0, cap}, {16'd0, fmask(tx, wide)});
    rd(2'd1, v);
    chk("R7 R6 slave received word", {16'd0, v}, {16'd0, fmask(sw, wide)});
    chk("R8 slave one irq pulse", irq_cnt - base, 1);
    slave_mode = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-all actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 reset mode", {16'd0, v}, 32'd0);
    rd(2'd1, v); chk("R1 reset rx", {16'd0, v}, 32'd0);
    rd(2'd2, v); chk("R1 reset status", {16'd0, v}, 32'd0);
    chk("R1 reset pins", {28'd0, sck_o, sout_o, irq_o, sck_oe_o}, 32'hC);
    wr(2'd0, 16'h00F7);
    rd(2'd0, v); chk("R1 mode readback", {16'd0, v}, 32'hF7);

    master_xfer(1'b1, 1'b0, 4'd0, 16'h12A5, 16'h003C, 1'b0);
    master_xfer(1'b0, 1'b0, 4'd2, 16'hFF81, 16'hBEC6, 1'b0);
    master_xfer(1'b1, 1'b1, 4'd5, 16'hC3A1, 16'h5A0F, 1'b0);
    master_xfer(1'b0, 1'b1, 4'd1, 16'h8001, 16'h7FFE, 1'b0);
    master_xfer(1'b1, 1'b1, 4'd15, 16'hA55A, 16'h0F0F, 1'b0);
    master_xfer(1'b1, 1'b1, 4'd3, 16'h9C31, 16'hE007, 1'b1);
    slave_xfer(1'b1, 1'b1, 16'hD00B, 16'h2468);
    slave_xfer(1'b0, 1'b0, 16'h4C96, 16'h00A7);

    for (int i = 0; i < 12; i++) begin
      logic        m, msb, wide;
      logic [3:0]  div;
      logic [15:0] tx, sw;
      m = 1'($urandom_range(0, 3) != 0);
      msb = 1'($urandom_range(0, 1));
      wide = 1'($urandom_range(0, 1));
      div = 4'($urandom_range(0, 4));
      tx = 16'($urandom);
      sw = 16'($urandom);
      if (m) master_xfer(msb, wide, div, tx, sw, 1'b0);
      else   slave_xfer(msb, wide, tx, sw);
    end

    summary();
    $finish;
  end
endmodule